// File: doc/BRIEF.md
# Flash Controller Event Status and Recovery Unit

This block is the status and interrupt front end of a serial flash controller. It collects eight single-cycle event pulses from the FIFO, the command sequencer and the DMA path. Each event is recorded in a sticky raw status bit whether or not the event is masked. Software picks which recorded events may raise the single interrupt line. It reads the pending view, and it clears bits one at a time by writing ones.

The unit also reads back the live FIFO level flags, holds the transmit and receive threshold levels that it drives to the FIFO, and runs the recovery command. A recovery write raises a reset request toward the FIFO and the sequencer. The request stays high, and reads back as 1, until those blocks report that their reset is complete. Recovery leaves the mask and the raw status alone, so software clears them itself afterwards.

Software reaches the unit through a simple word-addressed register port. Writes take effect at the clock edge. Read data is registered and appears one cycle after the address is presented.

Top module: `flash_evt_unit`

## Requirements
- R1: Raw status bit i is set on the clock edge after event input bit i pulses, whether or not that bit is masked. The event bit order is: 0 receive full, 1 receive underflow, 2 transmit overflow, 3 transmit empty, 4 transfer finished, 5 bus error, 6 serial protocol error, 7 DMA done.
- R2: A raw status bit stays set until software writes a 1 to the same bit of the clear register (word 1). A 0 written to a bit of the clear register leaves that bit unchanged, and the clear register reads as 0.
- R3: When an event pulse and a clear write hit the same bit in the same cycle, the bit stays set.
- R4: A 1 in the mask register (word 0, reset value 0xFF) disables that source. The pending register (word 2) reads raw AND NOT mask. The raw register (word 3) reads the raw bits and resets to 0.
- R5: The interrupt output is registered. It equals the OR of all pending bits one cycle later, so it is low whenever no unmasked bit is pending.
- R6: The FIFO flag register (word 4) reads transmit full in bit 0, transmit empty in bit 1, receive empty in bit 2 and receive full in bit 3, taken from the flag inputs. Its upper bits read 0.
- R7: The threshold register (word 5) holds a 5-bit transmit level at bits 4:0 and a 5-bit receive level at bits 12:8. Both levels drive their outputs and reset to 0. The other bits read 0.
- R8: Writing 1 to bit 0 of the recovery register (word 6) raises the reset request output on the next edge. Bit 0 reads 1 while the request is active. The request falls on the edge where the done input is high. Writing 0 starts nothing.
- R9: A recovery command changes neither the mask nor the raw status bits.
- R10: Read data appears on the edge after the address is presented. Word 7 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_pulse | input | 8 | Event pulses, one bit per source |
| txf_full | input | 1 | Transmit FIFO full |
| txf_empty | input | 1 | Transmit FIFO empty |
| rxf_empty | input | 1 | Receive FIFO empty |
| rxf_full | input | 1 | Receive FIFO full |
| rcv_done | input | 1 | FIFO and sequencer report reset complete |
| rcv_req | output | 1 | Reset request to FIFO and sequencer |
| tx_level | output | 5 | Transmit threshold level |
| rx_level | output | 5 | Receive threshold level |
| irq | output | 1 | Interrupt output |

## Verification
An event pulse and a software clear can land on the same raw bit in the same cycle, and the event must win. The bench provokes this on purpose. It issues a clear write with the target bit's event input held high in the same cycle, then reads the raw register to confirm the bit survived. The random phase mixes clear writes with random event pulses on every step, and each read is judged against a model in which an arriving event overrides the clear.

// File: rtl/flash_evt_pkg.sv
package flash_evt_pkg;
  localparam int EVT_N   = 8;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 32;
  localparam int LVL_W   = 5;
  localparam int RXL_LSB = 8;

  typedef enum logic [ADDR_W-1:0] {
    RG_MASK  = 3'd0,
    RG_CLEAR = 3'd1,
    RG_PEND  = 3'd2,
    RG_RAW   = 3'd3,
    RG_FLAGS = 3'd4,
    RG_LEVEL = 3'd5,
    RG_RCV   = 3'd6,
    RG_NONE  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/evt_bank.sv
module evt_bank #(
  parameter int             N        = 8,
  parameter logic [N-1:0]   MASK_RST = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_i,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);
  logic [N-1:0] raw_q;
  logic [N-1:0] mask_q;
  logic         irq_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)               raw_q[g] <= 1'b0;
      else if (evt_i[g])     raw_q[g] <= 1'b1;
      else if (clr_i[g])     raw_q[g] <= 1'b0;
    end
    always_ff @(posedge clk) begin
      if (rst)          mask_q[g] <= MASK_RST[g];
      else if (mask_we) mask_q[g] <= mask_wdata[g];
    end
  end

  assign pend_o = raw_q & ~mask_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pend_o;
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  AST_EVT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw_q & $past(evt_i)) == $past(evt_i))); // R1
  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw_q & $past(raw_q & ~clr_i)) == $past(raw_q & ~clr_i))); // R2
  AST_CLEAR_EFFECT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw_q & $past(clr_i & ~evt_i)) == '0)); // R2
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (pend_o == '0) |=> !irq_o); // R5
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (pend_o != '0) |=> irq_o); // R5
endmodule

// File: rtl/rcv_ctrl.sv
module rcv_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic done_i,
  output logic busy_o
);
  logic busy_q;

  always_ff @(posedge clk) begin
    if (rst)                   busy_q <= 1'b0;
    else if (busy_q && done_i) busy_q <= 1'b0;
    else if (start_i)          busy_q <= 1'b1;
  end

  assign busy_o = busy_q;

  AST_RCV_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done_i) |=> busy_q); // R8
  AST_RCV_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (busy_q && done_i) |=> !busy_q); // R8
  AST_RCV_START: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && start_i) |=> busy_q); // R8
endmodule

// File: rtl/level_regs.sv
module level_regs #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] tx_wdata,
  input  logic [W-1:0] rx_wdata,
  output logic [W-1:0] tx_o,
  output logic [W-1:0] rx_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_o <= '0;
      rx_o <= '0;
    end else if (we) begin
      tx_o <= tx_wdata;
      rx_o <= rx_wdata;
    end
  end

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(tx_o) && $stable(rx_o))); // R7
endmodule

// File: rtl/flash_evt_unit.sv
module flash_evt_unit
  import flash_evt_pkg::*;
#(
  parameter int                 NEVT     = EVT_N,
  parameter int                 AW       = ADDR_W,
  parameter int                 DW       = DATA_W,
  parameter int                 LW       = LVL_W,
  parameter int                 RX_LSB   = RXL_LSB,
  parameter logic [NEVT-1:0]    MASK_RST = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NEVT-1:0] evt_pulse,
  input  logic            txf_full,
  input  logic            txf_empty,
  input  logic            rxf_empty,
  input  logic            rxf_full,
  input  logic            rcv_done,
  output logic            rcv_req,
  output logic [LW-1:0]   tx_level,
  output logic [LW-1:0]   rx_level,
  output logic            irq
);
  localparam int RX_MSB = RX_LSB + LW - 1;

  logic            wr_mask, wr_clear, wr_level, wr_rcv;
  logic [NEVT-1:0] clr_vec;
  logic [NEVT-1:0] raw_w, mask_w, pend_w;
  logic            busy_w;
  logic [DW-1:0]   rd_mux;
  logic [DW-1:0]   rdata_q;

  assign wr_mask  = reg_we && (reg_addr == RG_MASK);
  assign wr_clear = reg_we && (reg_addr == RG_CLEAR);
  assign wr_level = reg_we && (reg_addr == RG_LEVEL);
  assign wr_rcv   = reg_we && (reg_addr == RG_RCV) && reg_wdata[0];
  assign clr_vec  = wr_clear ? reg_wdata[NEVT-1:0] : '0;

  evt_bank #(.N(NEVT), .MASK_RST(MASK_RST)) u_evt (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (evt_pulse),
    .mask_we    (wr_mask),
    .mask_wdata (reg_wdata[NEVT-1:0]),
    .clr_i      (clr_vec),
    .raw_o      (raw_w),
    .mask_o     (mask_w),
    .pend_o     (pend_w),
    .irq_o      (irq)
  );

  rcv_ctrl u_rcv (
    .clk     (clk),
    .rst     (rst),
    .start_i (wr_rcv),
    .done_i  (rcv_done),
    .busy_o  (busy_w)
  );

  level_regs #(.W(LW)) u_lvl (
    .clk      (clk),
    .rst      (rst),
    .we       (wr_level),
    .tx_wdata (reg_wdata[LW-1:0]),
    .rx_wdata (reg_wdata[RX_MSB:RX_LSB]),
    .tx_o     (tx_level),
    .rx_o     (rx_level)
  );

  assign rcv_req = busy_w;

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      RG_MASK:  rd_mux[NEVT-1:0] = mask_w;
      RG_PEND:  rd_mux[NEVT-1:0] = pend_w;
      RG_RAW:   rd_mux[NEVT-1:0] = raw_w;
      RG_FLAGS: rd_mux[3:0] = {rxf_full, rxf_empty, txf_empty, txf_full};
      RG_LEVEL: begin
        rd_mux[LW-1:0]        = tx_level;
        rd_mux[RX_MSB:RX_LSB] = rx_level;
      end
      RG_RCV:   rd_mux[0] = busy_w;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end
  assign reg_rdata = rdata_q;

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[DW-1:RX_MSB+1], reg_wdata[RX_LSB-1:LW]};

  AST_RCV_KEEPS_MASK: assert property (@(posedge clk) disable iff (rst)
    (busy_w && !wr_mask) |=> $stable(mask_w)); // R9
  AST_RCV_KEEPS_RAW: assert property (@(posedge clk) disable iff (rst)
    (busy_w && !wr_clear && evt_pulse == '0) |=> $stable(raw_w)); // R9
  AST_REQ_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!busy_w && !wr_rcv) |=> !rcv_req); // R8
endmodule

// File: tb/sim_flash_evt_unit.sv
module sim_flash_evt_unit;
  logic        clk = 0;
  logic        rst = 1;
  logic        reg_we = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [7:0]  evt_pulse = 0;
  logic        txf_full = 0, txf_empty = 0, rxf_empty = 0, rxf_full = 0;
  logic        rcv_done = 0;
  logic        rcv_req;
  logic [4:0]  tx_level, rx_level;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0] m_raw, m_mask;

  always #10 clk = ~clk;

  flash_evt_unit u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .txf_full(txf_full), .txf_empty(txf_empty), .rxf_empty(rxf_empty),
    .rxf_full(rxf_full), .rcv_done(rcv_done), .rcv_req(rcv_req),
    .tx_level(tx_level), .rx_level(rx_level), .irq(irq)
  );

  function automatic logic [7:0] f_pend(logic [7:0] r, logic [7:0] m);
    return r & ~m;
  endfunction

  function automatic logic [7:0] f_raw_next(logic [7:0] r, logic [7:0] e, logic [7:0] c);
    return (r & ~c) | e;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: optional write plus event pulses, updates the model
  task automatic step(bit we, logic [2:0] a, logic [31:0] d, logic [7:0] e);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; evt_pulse = e;
    @(posedge clk);
    m_raw = f_raw_next(m_raw, e, (we && a == 3'd1) ? d[7:0] : 8'h00);
    if (we && a == 3'd0) m_mask = d[7:0];
    @(negedge clk);
    reg_we = 0; evt_pulse = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_we = 0; reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    m_raw = 0; m_mask = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // reset state
    rd(3'd0, v); check("R4 mask reset", v, 32'hFF);
    rd(3'd3, v); check("R4 raw reset", v, 0);
    check("R5 irq reset", irq, 0);
    check("R8 req reset", rcv_req, 0);
    rd(3'd5, v); check("R7 level reset", v, 0);

    // masked event still recorded
    step(0, 0, 0, 8'h20);
    rd(3'd3, v); check("R1 raw bit5 while masked", v, 32'h20);
    rd(3'd2, v); check("R4 pending masked", v, 0);
    check("R5 irq low masked", irq, 0);

    // each source lands in its own bit
    for (int i = 0; i < 8; i++) begin
      step(1, 3'd1, 32'hFF, 8'h00);
      step(0, 0, 0, 8'(1 << i));
      rd(3'd3, v); check("R1 event order", v, 32'(1 << i));
    end

    // unmask bit 7 -> irq
    step(1, 3'd0, 32'h7F, 0);
    rd(3'd2, v); check("R4 pending after unmask", v, 32'h80);
    check("R5 irq raised", irq, 1);

    // clear with zeros: no effect
    step(1, 3'd1, 32'h7F, 0);
    rd(3'd3, v); check("R2 zero clear no effect", v, 32'h80);
    rd(3'd1, v); check("R2 clear reads zero", v, 0);

    // event and clear same bit same cycle
    step(1, 3'd1, 32'h80, 8'h80);
    rd(3'd3, v); check("R3 event beats clear", v, 32'h80);
    step(1, 3'd1, 32'h80, 0);
    rd(3'd3, v); check("R2 clear works", v, 0);
    check("R5 irq drops", irq, 0);

    // FIFO flags
    @(negedge clk); txf_full = 1; txf_empty = 0; rxf_empty = 0; rxf_full = 0;
    rd(3'd4, v); check("R6 tx full bit0", v, 32'h1);
    @(negedge clk); txf_full = 0; txf_empty = 1; rxf_empty = 1; rxf_full = 0;
    rd(3'd4, v); check("R6 tx empty+rx empty", v, 32'h6);
    @(negedge clk); txf_empty = 0; rxf_empty = 0; rxf_full = 1;
    rd(3'd4, v); check("R6 rx full bit3", v, 32'h8);

    // thresholds
    step(1, 3'd5, 32'hFFFF_FFFF, 0);
    rd(3'd5, v); check("R7 level readback", v, 32'h1F1F);
    check("R7 tx out", tx_level, 5'h1F); check("R7 rx out", rx_level, 5'h1F);
    step(1, 3'd5, 32'h0000_0A03, 0);
    check("R7 tx out 2", tx_level, 5'h03); check("R7 rx out 2", rx_level, 5'h0A);

    // recovery
    step(1, 3'd6, 32'h0, 0);
    check("R8 write zero no start", rcv_req, 0);
    step(1, 3'd0, 32'h0F, 8'h11);
    step(1, 3'd6, 32'h1, 0);
    check("R8 req raised", rcv_req, 1);
    rd(3'd6, v); check("R8 reads busy", v, 1);
    rd(3'd6, v); check("R8 still busy", v, 1);
    rd(3'd3, v); check("R9 raw kept", v, 32'h11);
    rd(3'd0, v); check("R9 mask kept", v, 32'h0F);
    @(negedge clk); rcv_done = 1;
    @(negedge clk); rcv_done = 0;
    check("R8 req released", rcv_req, 0);
    rd(3'd6, v); check("R8 reads done", v, 0);
    rd(3'd3, v); check("R9 raw after rcv", v, 32'h11);
    rd(3'd7, v); check("R10 unmapped reads zero", v, 0);

    // random phase
    for (int n = 0; n < 300; n++) begin
      logic [7:0]  e;
      logic [31:0] d;
      int          k;
      e = 8'($urandom & $urandom & $urandom);
      d = $urandom;
      k = $urandom_range(0, 3);
      if (k == 0)      step(1, 3'd0, d, e);
      else if (k == 1) step(1, 3'd1, d, e);
      else             step(0, 3'd0, 0, e);
      rd(3'd3, v); check("R1 R2 R3 random raw", v, {24'h0, m_raw});
      rd(3'd2, v); check("R4 random pending", v, {24'h0, f_pend(m_raw, m_mask)});
      check("R5 random irq", irq, |f_pend(m_raw, m_mask));
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule